// File: doc/BRIEF.md
# Low-Power State Sequencer

This block holds the power state of a small microcontroller-style system and drives the clock-gating enables that go with it. It has four states: RUN, HALT, STOP and SNOOZE. The CPU asks for HALT or STOP through request lines. Interrupt lines bring the system back to RUN. Which interrupts can do this depends on how deep the system sleeps. Interrupts from peripherals on the fast clock wake only HALT. External interrupts and interrupts from low-speed-clocked peripherals (wake-up timer included) wake both HALT and STOP.

From STOP there is a middle path. A serial-reception detect or a timed conversion trigger moves the system into SNOOZE. In SNOOZE the fast oscillator and the one chosen peripheral run, and the CPU stays gated. The peripheral then reports a qualification result. A pass (valid frame, or conversion inside its compare criterion) wakes the system to RUN. A fail returns it to STOP without the CPU ever running. A one-cycle abort strobe goes with the return, and the peripheral uses it to clear its pending event. An active-low asynchronous reset forces RUN from any state.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and straight after it rises, the state code is RUN. `cpu_clk_en`, `per_clk_en` and `hosc_en` are all 1, `snz_per_en` is 0 and `snz_abort` is 0. Asserting `rst_n` low in any state returns these values at once, without waiting for a clock edge.
- R2: In RUN, `halt_req` high moves the state to HALT at the next edge. If `halt_req` and `stop_req` are high together, HALT is chosen. Both request lines have no effect in HALT, STOP and SNOOZE.
- R3: In RUN, `stop_req` high with `halt_req` low moves the state to STOP at the next edge.
- R4: In HALT, any bit of `ext_irq`, `lsp_irq` or `hsp_irq` moves the state to RUN at the next edge.
- R5: In STOP, any bit of `ext_irq` or `lsp_irq` moves the state to RUN at the next edge. This holds even when a snooze event is present in the same cycle. `hsp_irq` has no effect in STOP.
- R6: In STOP with no wake interrupt, `snz_rx_det` or `snz_conv_trig` moves the state to SNOOZE. `snz_per_en` then enables the chosen peripheral: bit 0 is serial and bit 1 is converter. If both events arrive in the same cycle, serial wins. `snz_per_en` is 0 outside SNOOZE, and snooze events have no effect outside STOP.
- R7: In SNOOZE, `qual_valid` high with `qual_ok` high moves the state to RUN at the next edge.
- R8: In SNOOZE, `qual_valid` high with `qual_ok` low moves the state to STOP. In the first STOP cycle `snz_abort` is 1, and it is 1 for exactly that one cycle.
- R9: In SNOOZE, any bit of `ext_irq` or `lsp_irq` moves the state to RUN and takes priority over a qualification result in the same cycle. In that case no abort strobe is made. `hsp_irq`, `halt_req` and `stop_req` have no effect in SNOOZE.
- R10: `state_code` encodes 00 RUN, 01 HALT, 10 STOP, 11 SNOOZE. The enables `{cpu_clk_en, per_clk_en, hosc_en}` are 111 in RUN, 011 in HALT, 000 in STOP and 001 in SNOOZE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, forces RUN |
| halt_req | input | 1 | CPU request to enter HALT |
| stop_req | input | 1 | CPU request to enter STOP |
| ext_irq | input | EXT_W | External interrupt lines, already masked |
| lsp_irq | input | LSP_W | Interrupts from low-speed-clocked peripherals and wake-up timer |
| hsp_irq | input | HSP_W | Interrupts from peripherals on the fast clock |
| snz_rx_det | input | 1 | Serial reception detected while stopped |
| snz_conv_trig | input | 1 | Timed conversion trigger while stopped |
| qual_valid | input | 1 | Qualification result strobe from the snoozing peripheral |
| qual_ok | input | 1 | Qualification outcome: 1 pass, 0 fail |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | General peripheral clock enable |
| hosc_en | output | 1 | High-speed oscillator enable |
| state_code | output | 2 | Current state code |
| snz_per_en | output | 2 | One-hot enable of the snoozing peripheral |
| snz_abort | output | 1 | One-cycle strobe on a failed snooze, clears the pending event |

## Verification
Every output is decoded from registered state, so a wrong state shows up in the same cycle that the state changes. It is seen on `state_code`, and at the same time on the three clock enables and the snooze peripheral select. A wrong transition is therefore visible one clock after the stimulus that caused it. A lost or doubled abort strobe shows up on `snz_abort` in the first cycle after the return to STOP. The priority cases are all driven in the same cycle. These are interrupt against qualification, HALT against STOP, and serial against converter. A swapped priority therefore gives a different state code at the very next sample.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'b00,
      ST_HALT = 2'b01,
      ST_STOP = 2'b10,
      ST_SNZ  = 2'b11
   } lpm_state_e;

   localparam int SNZ_SRC_N = 2;
   localparam int SRC_W     = $clog2(SNZ_SRC_N);

   localparam logic [SRC_W-1:0] SRC_SERIAL = SRC_W'(0);
   localparam logic [SRC_W-1:0] SRC_CONV   = SRC_W'(1);

   typedef struct packed {
      logic cpu;
      logic per;
      logic hosc;
   } clk_en_t;

endpackage

// File: rtl/lpm_wake_arb.sv
module lpm_wake_arb #(
   parameter int EXT_W = 2,
   parameter int LSP_W = 2,
   parameter int HSP_W = 3
) (
   input  logic [EXT_W-1:0] ext_irq,
   input  logic [LSP_W-1:0] lsp_irq,
   input  logic [HSP_W-1:0] hsp_irq,
   output logic             wake_any,
   output logic             wake_deep
);

   generate
      if (EXT_W < 1) begin : g_bad_ext
         $error("lpm_wake_arb: EXT_W must be at least 1");
      end
      if (LSP_W < 1) begin : g_bad_lsp
         $error("lpm_wake_arb: LSP_W must be at least 1");
      end
      if (HSP_W < 1) begin : g_bad_hsp
         $error("lpm_wake_arb: HSP_W must be at least 1");
      end
   endgenerate

   logic ext_any;
   logic lsp_any;
   logic hsp_any;

   // Single-line groups skip the reduction tree.
   generate
      if (EXT_W == 1) begin : g_ext_one
         assign ext_any = ext_irq[0];
      end else begin : g_ext_many
         assign ext_any = |ext_irq;
      end
      if (LSP_W == 1) begin : g_lsp_one
         assign lsp_any = lsp_irq[0];
      end else begin : g_lsp_many
         assign lsp_any = |lsp_irq;
      end
      if (HSP_W == 1) begin : g_hsp_one
         assign hsp_any = hsp_irq[0];
      end else begin : g_hsp_many
         assign hsp_any = |hsp_irq;
      end
   endgenerate

   // Deep wake: sources that still have a running clock in STOP/SNOOZE.
   assign wake_deep = ext_any | lsp_any;
   assign wake_any  = wake_deep | hsp_any;

endmodule

// File: rtl/lpm_next_state.sv
module lpm_next_state
   import lpm_pkg::*;
(
   input  lpm_state_e       cur,
   input  logic [SRC_W-1:0] cur_src,
   input  logic             halt_req,
   input  logic             stop_req,
   input  logic             wake_any,
   input  logic             wake_deep,
   input  logic             rx_det,
   input  logic             conv_trig,
   input  logic             qual_valid,
   input  logic             qual_ok,
   output lpm_state_e       nxt,
   output logic [SRC_W-1:0] nxt_src,
   output logic             abort_set
);

   always_comb begin
      nxt       = cur;
      nxt_src   = cur_src;
      abort_set = 1'b0;
      case (cur)
         ST_RUN: begin
            if (halt_req) begin
               nxt = ST_HALT;
            end else if (stop_req) begin
               nxt = ST_STOP;
            end
         end
         ST_HALT: begin
            if (wake_any) begin
               nxt = ST_RUN;
            end
         end
         ST_STOP: begin
            if (wake_deep) begin
               nxt = ST_RUN;
            end else if (rx_det || conv_trig) begin
               nxt     = ST_SNZ;
               nxt_src = rx_det ? SRC_SERIAL : SRC_CONV;
            end
         end
         ST_SNZ: begin
            if (wake_deep) begin
               nxt = ST_RUN;
            end else if (qual_valid) begin
               if (qual_ok) begin
                  nxt = ST_RUN;
               end else begin
                  nxt       = ST_STOP;
                  abort_set = 1'b1;
               end
            end
         end
         default: nxt = ST_RUN;
      endcase
   end

endmodule

// File: rtl/lpm_state_reg.sv
module lpm_state_reg
   import lpm_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lpm_state_e       nxt,
   input  logic [SRC_W-1:0] nxt_src,
   input  logic             abort_set,
   output lpm_state_e       cur,
   output logic [SRC_W-1:0] cur_src,
   output logic             abort_q
);

   localparam int N_ST = 4;

   generate
      if (ONEHOT) begin : g_onehot
         logic [N_ST-1:0] oh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               oh_q <= N_ST'(1);
            end else begin
               oh_q <= N_ST'(1) << nxt;
            end
         end
         always_comb begin
            if (oh_q[3]) begin
               cur = ST_SNZ;
            end else if (oh_q[2]) begin
               cur = ST_STOP;
            end else if (oh_q[1]) begin
               cur = ST_HALT;
            end else begin
               cur = ST_RUN;
            end
         end
      end else begin : g_binary
         lpm_state_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q <= ST_RUN;
            end else begin
               st_q <= nxt;
            end
         end
         assign cur = st_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_src <= SRC_SERIAL;
         abort_q <= 1'b0;
      end else begin
         cur_src <= nxt_src;
         abort_q <= abort_set;
      end
   end

endmodule

// File: rtl/lpm_clk_dec.sv
module lpm_clk_dec
   import lpm_pkg::*;
(
   input  lpm_state_e           cur,
   input  logic [SRC_W-1:0]     cur_src,
   output clk_en_t              en,
   output logic [SNZ_SRC_N-1:0] snz_per_en
);

   always_comb begin
      case (cur)
         ST_RUN:  en = '{cpu: 1'b1, per: 1'b1, hosc: 1'b1};
         ST_HALT: en = '{cpu: 1'b0, per: 1'b1, hosc: 1'b1};
         ST_STOP: en = '{cpu: 1'b0, per: 1'b0, hosc: 1'b0};
         ST_SNZ:  en = '{cpu: 1'b0, per: 1'b0, hosc: 1'b1};
         default: en = '{cpu: 1'b1, per: 1'b1, hosc: 1'b1};
      endcase
   end

   generate
      for (genvar i = 0; i < SNZ_SRC_N; i++) begin : g_sel
         assign snz_per_en[i] = (cur == ST_SNZ) && (cur_src == SRC_W'(i));
      end
   endgenerate

endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
   import lpm_pkg::*;
#(
   parameter int EXT_W  = 2,
   parameter int LSP_W  = 2,
   parameter int HSP_W  = 3,
   parameter bit ONEHOT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_req,
   input  logic             stop_req,
   input  logic [EXT_W-1:0] ext_irq,
   input  logic [LSP_W-1:0] lsp_irq,
   input  logic [HSP_W-1:0] hsp_irq,
   input  logic             snz_rx_det,
   input  logic             snz_conv_trig,
   input  logic             qual_valid,
   input  logic             qual_ok,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             hosc_en,
   output logic [1:0]       state_code,
   output logic [1:0]       snz_per_en,
   output logic             snz_abort
);

   generate
      if (SNZ_SRC_N != 2) begin : g_bad_src
         $error("lpm_seq_ctrl: port snz_per_en assumes two snooze sources");
      end
   endgenerate

   logic             wake_any;
   logic             wake_deep;
   lpm_state_e       cur;
   lpm_state_e       nxt;
   logic [SRC_W-1:0] cur_src;
   logic [SRC_W-1:0] nxt_src;
   logic             abort_set;
   clk_en_t          en;

   lpm_wake_arb #(
      .EXT_W (EXT_W),
      .LSP_W (LSP_W),
      .HSP_W (HSP_W)
   ) u_wake (
      .ext_irq   (ext_irq),
      .lsp_irq   (lsp_irq),
      .hsp_irq   (hsp_irq),
      .wake_any  (wake_any),
      .wake_deep (wake_deep)
   );

   lpm_next_state u_nxt (
      .cur        (cur),
      .cur_src    (cur_src),
      .halt_req   (halt_req),
      .stop_req   (stop_req),
      .wake_any   (wake_any),
      .wake_deep  (wake_deep),
      .rx_det     (snz_rx_det),
      .conv_trig  (snz_conv_trig),
      .qual_valid (qual_valid),
      .qual_ok    (qual_ok),
      .nxt        (nxt),
      .nxt_src    (nxt_src),
      .abort_set  (abort_set)
   );

   lpm_state_reg #(
      .ONEHOT (ONEHOT)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt       (nxt),
      .nxt_src   (nxt_src),
      .abort_set (abort_set),
      .cur       (cur),
      .cur_src   (cur_src),
      .abort_q   (snz_abort)
   );

   lpm_clk_dec u_dec (
      .cur        (cur),
      .cur_src    (cur_src),
      .en         (en),
      .snz_per_en (snz_per_en)
   );

   assign cpu_clk_en = en.cpu;
   assign per_clk_en = en.per;
   assign hosc_en    = en.hosc;
   assign state_code = cur;

endmodule

// File: rtl/lpm_seq_ctrl_chk.sv
module lpm_seq_ctrl_chk #(
   parameter int EXT_W = 2,
   parameter int LSP_W = 2,
   parameter int HSP_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             halt_req,
   input logic             stop_req,
   input logic [EXT_W-1:0] ext_irq,
   input logic [LSP_W-1:0] lsp_irq,
   input logic [HSP_W-1:0] hsp_irq,
   input logic             snz_rx_det,
   input logic             snz_conv_trig,
   input logic             qual_valid,
   input logic             qual_ok,
   input logic             cpu_clk_en,
   input logic             per_clk_en,
   input logic             hosc_en,
   input logic [1:0]       state_code,
   input logic [1:0]       snz_per_en,
   input logic             snz_abort
);

   logic deep;
   logic any_irq;
   assign deep    = (|ext_irq) | (|lsp_irq);
   assign any_irq = deep | (|hsp_irq);

   p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b00 && halt_req) |=> state_code == 2'b01);

   p_stop_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b00 && !halt_req && stop_req) |=> state_code == 2'b10);

   p_halt_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b01 && any_irq) |=> state_code == 2'b00);

   p_stop_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b10 && deep) |=> state_code == 2'b00);

   p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b10 && !deep && !snz_rx_det && !snz_conv_trig)
      |=> state_code == 2'b10);

   p_serial_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b10 && !deep && snz_rx_det)
      |=> (state_code == 2'b11 && snz_per_en == 2'b01));

   p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(snz_per_en) && ((snz_per_en != 2'b00) == (state_code == 2'b11)));

   p_qual_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b11 && !deep && qual_valid && qual_ok) |=> state_code == 2'b00);

   p_qual_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b11 && !deep && qual_valid && !qual_ok)
      |=> (state_code == 2'b10 && snz_abort));

   p_abort_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snz_abort |=> !snz_abort);

   p_abort_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snz_abort) |-> $past(state_code) == 2'b11);

   p_irq_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b11 && deep) |=> (state_code == 2'b00 && !snz_abort));

   p_enc_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b00) |-> (cpu_clk_en && per_clk_en && hosc_en));

   p_enc_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b01) |-> (!cpu_clk_en && per_clk_en && hosc_en));

   p_enc_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b10) |-> (!cpu_clk_en && !per_clk_en && !hosc_en));

   p_enc_snz_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b11) |-> (!cpu_clk_en && !per_clk_en && hosc_en));

endmodule

bind lpm_seq_ctrl lpm_seq_ctrl_chk #(
   .EXT_W (EXT_W),
   .LSP_W (LSP_W),
   .HSP_W (HSP_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .halt_req      (halt_req),
   .stop_req      (stop_req),
   .ext_irq       (ext_irq),
   .lsp_irq       (lsp_irq),
   .hsp_irq       (hsp_irq),
   .snz_rx_det    (snz_rx_det),
   .snz_conv_trig (snz_conv_trig),
   .qual_valid    (qual_valid),
   .qual_ok       (qual_ok),
   .cpu_clk_en    (cpu_clk_en),
   .per_clk_en    (per_clk_en),
   .hosc_en       (hosc_en),
   .state_code    (state_code),
   .snz_per_en    (snz_per_en),
   .snz_abort     (snz_abort)
);

// File: tb/lpm_seq_ctrl_tb.sv
module lpm_seq_ctrl_tb;

   localparam int EXT_W = 2;
   localparam int LSP_W = 2;
   localparam int HSP_W = 3;

   // stimulus bit positions
   localparam int I_HALT = 0;
   localparam int I_STOP = 1;
   localparam int I_EXT  = 2;
   localparam int I_LSP  = 3;
   localparam int I_HSP  = 4;
   localparam int I_RX   = 5;
   localparam int I_TRIG = 6;
   localparam int I_QV   = 7;
   localparam int I_QOK  = 8;

   localparam logic [1:0] S_RUN  = 2'b00;
   localparam logic [1:0] S_HALT = 2'b01;
   localparam logic [1:0] S_STOP = 2'b10;
   localparam logic [1:0] S_SNZ  = 2'b11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             halt_req = 1'b0;
   logic             stop_req = 1'b0;
   logic [EXT_W-1:0] ext_irq = '0;
   logic [LSP_W-1:0] lsp_irq = '0;
   logic [HSP_W-1:0] hsp_irq = '0;
   logic             snz_rx_det = 1'b0;
   logic             snz_conv_trig = 1'b0;
   logic             qual_valid = 1'b0;
   logic             qual_ok = 1'b0;
   logic             cpu_clk_en;
   logic             per_clk_en;
   logic             hosc_en;
   logic [1:0]       state_code;
   logic [1:0]       snz_per_en;
   logic             snz_abort;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [1:0] st;
      logic [1:0] sel;
      logic       ab;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   always #5 clk = ~clk;

   lpm_seq_ctrl #(
      .EXT_W (EXT_W),
      .LSP_W (LSP_W),
      .HSP_W (HSP_W)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .halt_req      (halt_req),
      .stop_req      (stop_req),
      .ext_irq       (ext_irq),
      .lsp_irq       (lsp_irq),
      .hsp_irq       (hsp_irq),
      .snz_rx_det    (snz_rx_det),
      .snz_conv_trig (snz_conv_trig),
      .qual_valid    (qual_valid),
      .qual_ok       (qual_ok),
      .cpu_clk_en    (cpu_clk_en),
      .per_clk_en    (per_clk_en),
      .hosc_en       (hosc_en),
      .state_code    (state_code),
      .snz_per_en    (snz_per_en),
      .snz_abort     (snz_abort)
   );

   // enables {cpu, per, hosc} per state, from R10
   function automatic logic [2:0] en_for(input logic [1:0] st);
      case (st)
         S_RUN:   return 3'b111;
         S_HALT:  return 3'b011;
         S_STOP:  return 3'b000;
         default: return 3'b001;
      endcase
   endfunction

   task automatic compare(input exp_t e);
      logic [2:0] act_en;
      logic [2:0] exp_en;
      act_en = {cpu_clk_en, per_clk_en, hosc_en};
      exp_en = en_for(e.st);
      total++;
      if (state_code !== e.st || act_en !== exp_en || snz_per_en !== e.sel ||
          snz_abort !== e.ab) begin
         bad++;
         $display("FAIL %s: actual st=%b en=%b sel=%b ab=%b expected st=%b en=%b sel=%b ab=%b",
                  e.tag, state_code, act_en, snz_per_en, snz_abort,
                  e.st, exp_en, e.sel, e.ab);
      end
   endtask

   // driver: apply one cycle of stimulus, push the expected post-edge result
   task automatic cyc(input string tag, input logic [8:0] in,
                      input logic [1:0] st, input logic [1:0] sel, input logic ab);
      exp_t e;
      @(negedge clk);
      halt_req      = in[I_HALT];
      stop_req      = in[I_STOP];
      ext_irq       = in[I_EXT] ? EXT_W'(1) << (EXT_W - 1) : '0;
      lsp_irq       = in[I_LSP] ? LSP_W'(1) : '0;
      hsp_irq       = in[I_HSP] ? HSP_W'(1) << (HSP_W - 1) : '0;
      snz_rx_det    = in[I_RX];
      snz_conv_trig = in[I_TRIG];
      qual_valid    = in[I_QV];
      qual_ok       = in[I_QOK];
      e.st  = st;
      e.sel = sel;
      e.ab  = ab;
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: one expected item per clock edge, sampled 2 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            compare(sb_q.pop_front());
         end
      end
   end

   function automatic logic [8:0] b(input int k);
      return 9'(1) << k;
   endfunction

   task automatic check_reset(input string tag);
      exp_t e;
      e.st = S_RUN; e.sel = 2'b00; e.ab = 1'b0; e.tag = tag;
      compare(e);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_reset("R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_reset("R1 after release");

      cyc("R10 idle run",               9'd0,                      S_RUN,  2'b00, 1'b0);
      cyc("R2 halt entry",              b(I_HALT),                 S_HALT, 2'b00, 1'b0);
      cyc("R2 stop_req ignored in halt", b(I_STOP),                S_HALT, 2'b00, 1'b0);
      cyc("R4 hsp irq wakes halt",      b(I_HSP),                  S_RUN,  2'b00, 1'b0);
      cyc("R2 halt beats stop",         b(I_HALT) | b(I_STOP),     S_HALT, 2'b00, 1'b0);
      cyc("R4 ext irq wakes halt",      b(I_EXT),                  S_RUN,  2'b00, 1'b0);
      cyc("R3 stop entry",              b(I_STOP),                 S_STOP, 2'b00, 1'b0);
      cyc("R5 hsp irq ignored in stop", b(I_HSP),                  S_STOP, 2'b00, 1'b0);
      cyc("R2 halt_req ignored in stop", b(I_HALT),                S_STOP, 2'b00, 1'b0);
      cyc("R6 qual ignored in stop",    b(I_QV) | b(I_QOK),        S_STOP, 2'b00, 1'b0);
      cyc("R5 lsp irq wakes stop",      b(I_LSP),                  S_RUN,  2'b00, 1'b0);
      cyc("R6 snooze event ignored in run", b(I_RX),               S_RUN,  2'b00, 1'b0);
      cyc("R3 stop entry again",        b(I_STOP),                 S_STOP, 2'b00, 1'b0);
      cyc("R6 serial beats converter",  b(I_RX) | b(I_TRIG),       S_SNZ,  2'b01, 1'b0);
      cyc("R6 snooze holds",            9'd0,                      S_SNZ,  2'b01, 1'b0);
      cyc("R7 qualified pass wakes",    b(I_QV) | b(I_QOK),        S_RUN,  2'b00, 1'b0);
      cyc("R3 stop entry 3",            b(I_STOP),                 S_STOP, 2'b00, 1'b0);
      cyc("R6 converter snooze",        b(I_TRIG),                 S_SNZ,  2'b10, 1'b0);
      cyc("R8 qualified fail back",     b(I_QV),                   S_STOP, 2'b00, 1'b1);
      cyc("R8 abort one cycle",         9'd0,                      S_STOP, 2'b00, 1'b0);
      cyc("R5 irq beats snooze event",  b(I_EXT) | b(I_RX),        S_RUN,  2'b00, 1'b0);
      cyc("R3 stop entry 4",            b(I_STOP),                 S_STOP, 2'b00, 1'b0);
      cyc("R6 serial snooze",           b(I_RX),                   S_SNZ,  2'b01, 1'b0);
      cyc("R9 irq beats fail",          b(I_LSP) | b(I_QV),        S_RUN,  2'b00, 1'b0);
      cyc("R3 stop entry 5",            b(I_STOP),                 S_STOP, 2'b00, 1'b0);
      cyc("R6 serial snooze 2",         b(I_RX),                   S_SNZ,  2'b01, 1'b0);
      cyc("R9 irq with pass",           b(I_EXT) | b(I_QV) | b(I_QOK), S_RUN, 2'b00, 1'b0);
      cyc("R3 stop entry 6",            b(I_STOP),                 S_STOP, 2'b00, 1'b0);
      cyc("R6 converter snooze 2",      b(I_TRIG),                 S_SNZ,  2'b10, 1'b0);
      cyc("R9 hsp irq ignored in snooze", b(I_HSP),                S_SNZ,  2'b10, 1'b0);
      cyc("R9 requests ignored in snooze", b(I_HALT) | b(I_STOP),  S_SNZ,  2'b10, 1'b0);
      cyc("R8 fail from converter",     b(I_QV),                   S_STOP, 2'b00, 1'b1);
      cyc("R5 ext wakes after abort",   b(I_EXT),                  S_RUN,  2'b00, 1'b0);
      cyc("R3 stop before reset",       b(I_STOP),                 S_STOP, 2'b00, 1'b0);
      cyc("R6 snooze before reset",     b(I_TRIG),                 S_SNZ,  2'b10, 1'b0);
      cyc("R6 idle",                    9'd0,                      S_SNZ,  2'b10, 1'b0);

      // asynchronous reset from SNOOZE, away from any edge
      @(negedge clk);
      wait (sb_q.size() == 0);
      #1;
      rst_n = 1'b0;
      #1;
      check_reset("R1 async reset from snooze");
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1 run after reset",         9'd0,                      S_RUN,  2'b00, 1'b0);

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog (R1..R10 run): actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule